// File: doc/BRIEF.md
# AAL5 Frame Trailer Checker

This block watches the payload stream of one ATM virtual channel and works out the receive status of each AAL5 frame. Cell payloads arrive one byte per cycle, with the cell's CLP bit and three PTI bits held steady for the whole cell. Across the cells of a frame the block keeps a running CRC32, a byte count and a sticky CLP flag. When the final cell ends, it reads the 8-byte trailer and emits one status strobe carrying all flags and the frame's length field.

Upstream logic keeps the bytes of a cell together and marks the first byte of each cell. Storing the payload and looking up the channel happen elsewhere. Management cells may be mixed into the stream. The block skips them without disturbing the frame being assembled.

Top module: `aal5_trailer_check`

## Requirements
- R1: A cell is `CELL_BYTES` (48) bytes long, and its first byte carries `in_first`=1. A user data cell with PTI bit 0 = 1 and PTI bit 2 = 0 ends the frame. `st_valid` pulses for exactly one cycle per frame, in the cycle after the final byte of that cell is accepted. Cells need not follow each other back to back.
- R2: `st_clp` is 1 when at least one data cell of the frame had CLP = 1.
- R3: `st_cng` equals PTI bit 1 of the final cell only. Congestion marks on earlier cells have no effect on it.
- R4: `st_abort` is 1 when the trailer length field is zero. While it is set, `st_len_err` and `st_crc_err` both read 0.
- R5: `st_uu_nz` is 1 when the user-to-user byte or the CPI byte of the trailer is nonzero.
- R6: The trailer fills the last 8 bytes of the final cell: user-to-user byte, then CPI byte, then the 16-bit length (MSB first), then the 32-bit CRC (MSB first). `st_len` reports the length field.
- R7: The pad count is total frame bytes minus 8 minus the length field. `st_len_err` is 1 when the pad count is below 0 or above 47. Pad counts of 0 and 47 are legal.
- R8: The CRC-32 uses polynomial 0x04C11DB7, all-ones preset, MSB-first bit order and a complemented result. It covers every frame byte before the CRC field. `st_crc_err` is 1 when the check over the whole frame fails, meaning the residue is not 0xC704DD7B.
- R9: Cells with PTI bit 2 = 1 are ignored. They produce no strobe, even when PTI bit 0 = 1, and they change neither the CRC, the byte count nor the CLP flag of the frame in progress.
- R10: After each strobe, the frame state starts over. A following frame's flags depend only on its own cells.
- R11: After reset `st_valid` and all status flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Payload byte present |
| in_first | input | 1 | Byte is the first of a cell |
| in_data | input | 8 | Payload byte |
| in_clp | input | 1 | Cell loss priority bit of the current cell |
| in_pti | input | 3 | Payload type bits of the current cell |
| st_valid | output | 1 | One-cycle status strobe per frame |
| st_clp | output | 1 | Some cell had CLP set |
| st_cng | output | 1 | Final cell carried congestion mark |
| st_abort | output | 1 | Length field was zero |
| st_uu_nz | output | 1 | User-to-user or CPI byte nonzero |
| st_len_err | output | 1 | Pad count out of range |
| st_crc_err | output | 1 | CRC check failed |
| st_len | output | 16 | Length field of the trailer |

## Verification
The bench builds the block with its default parameters: 48-byte cells, an 8-byte trailer and a 16-bit byte counter. Frames of one to three cells reach both ends of the pad range (0 and 47) and go past them on each side. The bench computes its own CRC for each frame. It places management cells between the data cells of a frame, including one whose PTI marks an end of frame. It mixes back-to-back cells with idle gaps, so cell framing is tested both with and without pauses.

// File: rtl/aal5_trailer_check.sv
module aal5_trailer_check #(
  parameter int          CELL_BYTES = 48,
  parameter int          TRL_BYTES  = 8,
  parameter int          CNT_W      = 16,
  parameter logic [31:0] CRC_POLY   = 32'h04C1_1DB7,
  parameter logic [31:0] CRC_GOOD   = 32'hC704_DD7B
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_first,
  input  logic [7:0]  in_data,
  input  logic        in_clp,
  input  logic [2:0]  in_pti,
  output logic        st_valid,
  output logic        st_clp,
  output logic        st_cng,
  output logic        st_abort,
  output logic        st_uu_nz,
  output logic        st_len_err,
  output logic        st_crc_err,
  output logic [15:0] st_len
);

  localparam int IDX_W   = $clog2(CELL_BYTES);
  localparam int TRL_AT  = CELL_BYTES - TRL_BYTES;
  localparam int PAD_MAX = CELL_BYTES - 1;
  localparam int EXT_W   = (CNT_W > 16 ? CNT_W : 16) + 8;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);
  localparam logic [IDX_W-1:0] UU_IDX   = IDX_W'(TRL_AT);
  localparam logic [IDX_W-1:0] CPI_IDX  = IDX_W'(TRL_AT + 1);
  localparam logic [IDX_W-1:0] LHI_IDX  = IDX_W'(TRL_AT + 2);
  localparam logic [IDX_W-1:0] LLO_IDX  = IDX_W'(TRL_AT + 3);

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 7; i >= 0; i--)
      r = {r[30:0], 1'b0} ^ ((r[31] ^ d[i]) ? CRC_POLY : 32'h0);
    return r;
  endfunction

  logic [IDX_W-1:0] idx, pos;
  logic             hdr_mgmt, hdr_last, hdr_cng;
  logic             acc_clp;
  logic [31:0]      crc, crc_fin;
  logic [CNT_W-1:0] total, total_fin;
  logic [7:0]       uu_b, cpi_b, len_hi, len_lo;

  logic cur_mgmt, cur_last, cur_cng, take, at_end, clp_now, abort_now, len_bad;
  logic [15:0]      len_val;
  logic [EXT_W-1:0] tot_ext, need_min, need_max;

  assign pos       = in_first ? '0 : idx;
  assign cur_mgmt  = in_first ? in_pti[2] : hdr_mgmt;
  assign cur_last  = in_first ? (in_pti[0] & ~in_pti[2]) : hdr_last;
  assign cur_cng   = in_first ? in_pti[1] : hdr_cng;
  assign take      = in_valid && !cur_mgmt;
  assign at_end    = take && cur_last && (pos == LAST_IDX);
  assign crc_fin   = crc_step(crc, in_data);
  assign clp_now   = acc_clp | (take & in_first & in_clp);
  assign total_fin = (total == '1) ? total : total + 1'b1;
  assign len_val   = {len_hi, len_lo};
  assign abort_now = (len_val == 16'h0);
  assign tot_ext   = EXT_W'(total_fin);
  assign need_min  = EXT_W'(len_val) + EXT_W'(TRL_BYTES);
  assign need_max  = need_min + EXT_W'(PAD_MAX);
  assign len_bad   = (tot_ext < need_min) || (tot_ext > need_max);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx        <= '0;
      hdr_mgmt   <= 1'b0;
      hdr_last   <= 1'b0;
      hdr_cng    <= 1'b0;
      acc_clp    <= 1'b0;
      crc        <= '1;
      total      <= '0;
      uu_b       <= '0;
      cpi_b      <= '0;
      len_hi     <= '0;
      len_lo     <= '0;
      st_valid   <= 1'b0;
      st_clp     <= 1'b0;
      st_cng     <= 1'b0;
      st_abort   <= 1'b0;
      st_uu_nz   <= 1'b0;
      st_len_err <= 1'b0;
      st_crc_err <= 1'b0;
      st_len     <= '0;
    end else begin
      st_valid <= 1'b0;
      if (in_valid) begin
        idx <= (pos == LAST_IDX) ? '0 : pos + 1'b1;
        if (in_first) begin
          hdr_mgmt <= in_pti[2];
          hdr_last <= in_pti[0] & ~in_pti[2];
          hdr_cng  <= in_pti[1];
        end
      end
      if (at_end) begin
        st_valid   <= 1'b1;
        st_clp     <= clp_now;
        st_cng     <= cur_cng;
        st_abort   <= abort_now;
        st_uu_nz   <= (uu_b != 8'h0) || (cpi_b != 8'h0);
        st_len     <= len_val;
        st_len_err <= !abort_now && len_bad;
        st_crc_err <= !abort_now && (crc_fin != CRC_GOOD);
        crc        <= '1;
        total      <= '0;
        acc_clp    <= 1'b0;
      end else if (take) begin
        crc     <= crc_fin;
        total   <= total_fin;
        acc_clp <= clp_now;
        if (cur_last) begin
          if (pos == UU_IDX)  uu_b   <= in_data;
          if (pos == CPI_IDX) cpi_b  <= in_data;
          if (pos == LHI_IDX) len_hi <= in_data;
          if (pos == LLO_IDX) len_lo <= in_data;
        end
      end
    end
  end

  assert_single_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |=> !st_valid);

  assert_strobe_follows_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> $past(in_valid));

  assert_idx_in_cell_R1: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= LAST_IDX);

  assert_abort_masks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_abort) |-> (!st_len_err && !st_crc_err));

  assert_mgmt_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_first && hdr_mgmt) |=> !st_valid);

endmodule

// File: tb/sim_aal5_trailer_check.sv
`timescale 1ns/1ps
module sim_aal5_trailer_check;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_first = 1'b0, in_clp = 1'b0;
  logic [7:0] in_data = 8'h0;
  logic [2:0] in_pti = 3'b000;
  logic st_valid, st_clp, st_cng, st_abort, st_uu_nz, st_len_err, st_crc_err;
  logic [15:0] st_len;

  always #2.5 clk = ~clk;

  aal5_trailer_check u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_data(in_data), .in_clp(in_clp), .in_pti(in_pti),
    .st_valid(st_valid), .st_clp(st_clp), .st_cng(st_cng), .st_abort(st_abort),
    .st_uu_nz(st_uu_nz), .st_len_err(st_len_err), .st_crc_err(st_crc_err),
    .st_len(st_len)
  );

  typedef struct {
    logic clp, cng, abrt, uu, lerr, cerr;
    int   len;
    string tag;
  } exp_t;

  exp_t expq[$];
  int checks = 0;
  int errors = 0;
  logic [7:0] fb [0:191];

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic logic [31:0] tb_crc(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[31] ^ d[i]) r = {r[30:0], 1'b0} ^ 32'h04C11DB7;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction

  always @(negedge clk) begin
    if (rst_n && st_valid) begin
      if (expq.size() == 0) begin
        chk("R9 unexpected status strobe", 1, 0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        chk({e.tag, " R2 clp"},      st_clp,     e.clp);
        chk({e.tag, " R3 cng"},      st_cng,     e.cng);
        chk({e.tag, " R4 abort"},    st_abort,   e.abrt);
        chk({e.tag, " R5 uu/cpi"},   st_uu_nz,   e.uu);
        chk({e.tag, " R6 length"},   st_len,     e.len);
        chk({e.tag, " R7 len_err"},  st_len_err, e.lerr);
        chk({e.tag, " R8 crc_err"},  st_crc_err, e.cerr);
      end
    end
  end

  task automatic send_cell(input logic [2:0] pti, input logic clp, input int base,
                           input bit gap, input bit junk);
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_first = (i == 0);
      in_pti   = pti;
      in_clp   = clp;
      in_data  = junk ? 8'(8'h5A ^ i) : fb[base + i];
    end
    if (gap) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_first = 1'b0;
    end
  endtask

  task automatic run_frame(input string tag, input int ncells, input int paylen,
                           input int len_field, input int clp_mask, input int cng_mask,
                           input logic [7:0] uu, input logic [7:0] cpi,
                           input bit corrupt, input int mgmt_at, input bit gaps);
    int nb, pad;
    logic [31:0] c;
    exp_t e;
    nb = ncells * 48;
    for (int i = 0; i < nb; i++) fb[i] = 8'h00;
    for (int i = 0; i < paylen && i < nb - 8; i++) fb[i] = 8'(i * 7 + ncells + 3);
    fb[nb-8] = uu;
    fb[nb-7] = cpi;
    fb[nb-6] = len_field[15:8];
    fb[nb-5] = len_field[7:0];
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < nb - 4; i++) c = tb_crc(c, fb[i]);
    c = ~c;
    fb[nb-4] = c[31:24];
    fb[nb-3] = c[23:16];
    fb[nb-2] = c[15:8];
    fb[nb-1] = c[7:0];
    if (corrupt) fb[1] = fb[1] ^ 8'h10;
    pad    = nb - 8 - len_field;
    e.tag  = tag;
    e.clp  = ((clp_mask & ((1 << ncells) - 1)) != 0);
    e.cng  = cng_mask[ncells-1];
    e.abrt = (len_field == 0);
    e.uu   = (uu != 8'h0) || (cpi != 8'h0);
    e.len  = len_field;
    e.lerr = !e.abrt && (pad < 0 || pad > 47);
    e.cerr = !e.abrt && corrupt;
    expq.push_back(e);
    for (int k = 0; k < ncells; k++) begin
      if (mgmt_at == k) send_cell(3'b101, 1'b1, 0, gaps, 1'b1);
      send_cell({1'b0, cng_mask[k], k == ncells - 1}, clp_mask[k], k * 48, gaps, 1'b0);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_first = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk("R1 watchdog run completion", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 st_valid after reset", st_valid, 0);
    chk("R11 flags after reset", {st_clp, st_cng, st_abort, st_uu_nz, st_len_err, st_crc_err}, 0);

    run_frame("R1 single cell",        1, 20, 20, 0, 0, 8'h00, 8'h00, 0, -1, 0);
    run_frame("R2 R3 early marks",     2, 60, 60, 1, 1, 8'h00, 8'h00, 0, -1, 0);
    run_frame("R10 fresh, R5 R7 pad0", 1, 40, 40, 0, 1, 8'h00, 8'h05, 0, -1, 1);
    run_frame("R7 pad too big",        2, 30, 30, 0, 0, 8'h11, 8'h00, 0, -1, 0);
    run_frame("R7 pad negative",       1, 40, 41, 0, 0, 8'h00, 8'h00, 0, -1, 0);
    run_frame("R7 pad 47",             2, 41, 41, 2, 2, 8'h00, 8'h00, 0, -1, 1);
    run_frame("R8 bad crc",            3, 120, 120, 4, 0, 8'h00, 8'h00, 1, -1, 0);
    run_frame("R4 abort masks",        2, 50, 0, 0, 0, 8'h00, 8'h00, 1, -1, 0);
    run_frame("R9 mgmt mid frame",     3, 100, 100, 0, 4, 8'h00, 8'h00, 0, 1, 1);
    send_cell(3'b101, 1'b1, 0, 1'b0, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    in_first = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 no strobe for lone mgmt cell", expq.size(), 0);
    run_frame("R9 R10 after mgmt",     1, 10, 10, 0, 0, 8'h00, 8'h00, 0, -1, 0);
    run_frame("R1 final mgmt before",  2, 70, 70, 0, 0, 8'h00, 8'h00, 0, 1, 0);

    repeat (10) @(negedge clk);
    chk("R1 every frame produced one strobe", expq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule